// File: doc/BRIEF.md
# I2C Controller Command Sequencer

This block holds the control register of a combined master/slave I2C controller. It turns software requests into one-cycle command strobes for the bit-level engine that drives the bus. The CPU writes and reads one 8-bit control word. The bits are interrupt enable, bus enable, start request, stop request, pending flag and acknowledge enable. The engine reports its status back to the block: bus free, master mode, slave transfer in progress, protocol state entries, bytes sent and address matches. The block answers with START, repeated START, STOP, local-stop and clock-release strobes, the acknowledge level and the interrupt line.

Start and stop requests are read in context. A START waits for a free bus and for any slave transfer to end, and it becomes a repeated START when the controller is already master and has sent a byte. A STOP requested while not master only resets the engine locally and drives nothing onto the bus. While the pending flag is set, the engine holds SCL low, so software paces every protocol step by clearing the flag.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Control word bit positions are: bit 7 interrupt enable, bit 6 bus enable, bit 5 start request, bit 4 stop request, bit 3 pending flag, bit 2 acknowledge enable. Bits 1:0 read 0. The whole word reads 0x00 after reset.
- R2: `irq` is 1 exactly when both the pending flag and interrupt enable are 1.
- R3: When bus enable is 0, engine state entries never set the flag, `addrAccept` stays 0 and no command strobe is issued. When bus enable is 1, `addrAccept` is 1 for an own-address match, and for a general call only while `gcEnable` is 1.
- R4: When not master, a pending start request issues a one-cycle `cmdStart` once `busFree` is 1 and `slaveActive` is 0. The start bit then reads 0. While the bus is busy, the request waits.
- R5: While master, a pending start issues `cmdRepStart` only after at least one `byteSent` pulse since master mode began or since the last command.
- R6: If a start request arrives while `slaveActive` is 1, nothing is issued until the slave transfer ends. `cmdStart` follows once the bus is free.
- R7: Writing 0 to the start or stop bit leaves a pending request unchanged.
- R8: A stop request while master issues a one-cycle `cmdStop`. When not master, it issues `cmdLocalStop` instead and never `cmdStop`. In both cases the stop bit then reads 0.
- R9: With start and stop both requested while master, `cmdStop` comes first. The start waits and is later issued as `cmdStart` once the engine has left master mode and the bus is free.
- R10: An engine entry into any state other than the idle state (`stateEnter`=1, `stateIsIdle`=0) sets the flag. An entry into the idle state does not. `sclHold` equals the flag.
- R11: A CPU write with bit 3 = 0 clears the flag and raises `cmdRelease` for one cycle. A write with bit 3 = 1 leaves the flag unchanged. If an engine set and a CPU clear fall in the same cycle, the flag stays 1.
- R12: `ackValue` is 1 (ACK) when acknowledge enable is 1 and 0 (NACK) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 8 | Control word write data |
| regRdData | output | 8 | Control word readback |
| gcEnable | input | 1 | General call answering enabled |
| busFree | input | 1 | Engine: bus idle |
| isMaster | input | 1 | Engine: currently bus master |
| slaveActive | input | 1 | Engine: addressed as slave, transfer running |
| stateEnter | input | 1 | Engine: a protocol state was entered this cycle |
| stateIsIdle | input | 1 | Engine: the entered state is the idle state |
| byteSent | input | 1 | Engine: a byte was transmitted as master |
| addrMatch | input | 1 | Engine: own slave address seen |
| genCallSeen | input | 1 | Engine: general call address seen |
| irq | output | 1 | Interrupt line |
| sclHold | output | 1 | Hold SCL low while flag pending |
| busActive | output | 1 | Gate for the engine's SCL/SDA input sampling |
| cmdStart | output | 1 | Issue START |
| cmdRepStart | output | 1 | Issue repeated START |
| cmdStop | output | 1 | Drive STOP on the bus |
| cmdLocalStop | output | 1 | Return to unaddressed idle without driving the bus |
| cmdRelease | output | 1 | Flag was cleared; release SCL |
| ackValue | output | 1 | Level for the acknowledge slot (1 = ACK) |
| addrAccept | output | 1 | Answer the address just seen |

## Verification
The bench targets four points. A start request made on a busy bus must not fire early or be dropped. A request made while master must become a repeated START and not a fresh START. A combined stop-and-start must not issue START before the engine has left master mode. A STOP in slave context must never reach the bus. A design that got the flag priority wrong would lose a state entry that lands in the same cycle as a CPU clear, and would leave the clock released while work is pending. A write of 1 to the flag that set or kept the flag wrongly shows up as a stuck or spurious interrupt. The bench also writes 0 to a pending start bit. A design that treated this as a clear would never issue the command.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_INTEN  = 7;
  localparam int BIT_BUSEN  = 6;
  localparam int BIT_START  = 5;
  localparam int BIT_STOP   = 4;
  localparam int BIT_FLAG   = 3;
  localparam int BIT_ACKEN  = 2;
  localparam int RSVD_W     = BIT_ACKEN;

  typedef struct packed {
    logic clrStart;
    logic clrStop;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_STOP,
    ACT_LSTOP,
    ACT_START,
    ACT_RSTART
  } seqAct_t;
endpackage

// File: rtl/i2c_seq_regs.sv
module i2c_seq_regs
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             stateEnter,
  input  logic             stateIsIdle,
  input  ctlStrobe_t       strobe,
  output logic [REG_W-1:0] regRdData,
  output logic             busEn,
  output logic             startReq,
  output logic             stopReq,
  output logic             irq,
  output logic             sclHold,
  output logic             cmdRelease,
  output logic             ackValue
);
  logic intEn, irqFlag, ackEn;
  logic flagSet, flagClr;

  // engine entries count only while the bus side is enabled
  assign flagSet = stateEnter && !stateIsIdle && busEn;
  assign flagClr = regWrEn && !regWrData[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn      <= 1'b0;
      busEn      <= 1'b0;
      startReq   <= 1'b0;
      stopReq    <= 1'b0;
      irqFlag    <= 1'b0;
      ackEn      <= 1'b0;
      cmdRelease <= 1'b0;
    end else begin
      if (regWrEn) begin
        intEn <= regWrData[BIT_INTEN];
        busEn <= regWrData[BIT_BUSEN];
        ackEn <= regWrData[BIT_ACKEN];
      end
      // request bits: a written 1 sets, a written 0 is ignored, issue clears
      startReq <= (startReq && !strobe.clrStart) ||
                  (regWrEn && regWrData[BIT_START]);
      stopReq  <= (stopReq && !strobe.clrStop) ||
                  (regWrEn && regWrData[BIT_STOP]);
      // engine set has priority over a CPU clear
      if (flagSet)      irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;
      cmdRelease <= irqFlag && flagClr && !flagSet;
    end
  end

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_INTEN] = intEn;
    regRdData[BIT_BUSEN] = busEn;
    regRdData[BIT_START] = startReq;
    regRdData[BIT_STOP]  = stopReq;
    regRdData[BIT_FLAG]  = irqFlag;
    regRdData[BIT_ACKEN] = ackEn;
  end

  assign irq      = irqFlag && intEn;
  assign sclHold  = irqFlag;
  assign ackValue = ackEn;
endmodule

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEn,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       isMaster,
  input  logic       slaveActive,
  input  logic       busFree,
  input  logic       byteSent,
  input  logic       addrMatch,
  input  logic       genCallSeen,
  input  logic       gcEnable,
  output ctlStrobe_t strobe,
  output logic       cmdStart,
  output logic       cmdRepStart,
  output logic       cmdStop,
  output logic       cmdLocalStop,
  output logic       addrAccept
);
  seqAct_t act;
  logic    sentAny;
  logic    anyCmd;

  // decide one action per cycle; stop always ranks above start
  always_comb begin
    act = ACT_NONE;
    if (busEn) begin
      if (stopReq) begin
        act = isMaster ? ACT_STOP : ACT_LSTOP;
      end else if (startReq) begin
        if (isMaster) begin
          if (sentAny) act = ACT_RSTART;
        end else if (busFree && !slaveActive) begin
          act = ACT_START;
        end
      end
    end
  end

  assign cmdStart     = (act == ACT_START);
  assign cmdRepStart  = (act == ACT_RSTART);
  assign cmdStop      = (act == ACT_STOP);
  assign cmdLocalStop = (act == ACT_LSTOP);
  assign anyCmd       = (act != ACT_NONE);

  assign strobe.clrStart = cmdStart || cmdRepStart;
  assign strobe.clrStop  = cmdStop || cmdLocalStop;

  // tracks whether a byte went out in the current master phase
  always_ff @(posedge clk) begin
    if (!rstN)                   sentAny <= 1'b0;
    else if (anyCmd || !isMaster) sentAny <= 1'b0;
    else if (byteSent)            sentAny <= 1'b1;
  end

  assign addrAccept = busEn && (addrMatch || (genCallSeen && gcEnable));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             gcEnable,
  input  logic             busFree,
  input  logic             isMaster,
  input  logic             slaveActive,
  input  logic             stateEnter,
  input  logic             stateIsIdle,
  input  logic             byteSent,
  input  logic             addrMatch,
  input  logic             genCallSeen,
  output logic             irq,
  output logic             sclHold,
  output logic             busActive,
  output logic             cmdStart,
  output logic             cmdRepStart,
  output logic             cmdStop,
  output logic             cmdLocalStop,
  output logic             cmdRelease,
  output logic             ackValue,
  output logic             addrAccept
);
  ctlStrobe_t strobe;
  logic busEn, startReq, stopReq;

  i2c_seq_regs u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .stateEnter(stateEnter), .stateIsIdle(stateIsIdle), .strobe(strobe),
    .regRdData(regRdData), .busEn(busEn), .startReq(startReq),
    .stopReq(stopReq), .irq(irq), .sclHold(sclHold),
    .cmdRelease(cmdRelease), .ackValue(ackValue)
  );

  i2c_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .startReq(startReq),
    .stopReq(stopReq), .isMaster(isMaster), .slaveActive(slaveActive),
    .busFree(busFree), .byteSent(byteSent), .addrMatch(addrMatch),
    .genCallSeen(genCallSeen), .gcEnable(gcEnable), .strobe(strobe),
    .cmdStart(cmdStart), .cmdRepStart(cmdRepStart), .cmdStop(cmdStop),
    .cmdLocalStop(cmdLocalStop), .addrAccept(addrAccept)
  );

  assign busActive = busEn;
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
  import i2c_seq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regRdData,
  input logic             isMaster,
  input logic             slaveActive,
  input logic             busFree,
  input logic             stateEnter,
  input logic             stateIsIdle,
  input logic             irq,
  input logic             cmdStart,
  input logic             cmdRepStart,
  input logic             cmdStop,
  input logic             cmdLocalStop,
  input logic             addrAccept
);
  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[BIT_INTEN] |-> !irq);

  a_r3_no_accept_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[BIT_BUSEN] |-> !addrAccept);

  a_r4_start_needs_free_bus: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> (busFree && !slaveActive && !isMaster));

  a_r4_start_self_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !regWrEn) |=> !regRdData[BIT_START]);

  a_r8_stop_only_master: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |-> isMaster);

  a_r9_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdStart, cmdRepStart, cmdStop, cmdLocalStop}));

  a_r11_engine_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stateEnter && !stateIsIdle && regRdData[BIT_BUSEN]) |=> regRdData[BIT_FLAG]);

  a_r10_idle_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[BIT_FLAG] && !(stateEnter && !stateIsIdle)) |=> !regRdData[BIT_FLAG]);
endmodule

bind i2c_cmd_seq i2c_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .isMaster(isMaster), .slaveActive(slaveActive), .busFree(busFree),
  .stateEnter(stateEnter), .stateIsIdle(stateIsIdle), .irq(irq),
  .cmdStart(cmdStart), .cmdRepStart(cmdRepStart), .cmdStop(cmdStop),
  .cmdLocalStop(cmdLocalStop), .addrAccept(addrAccept)
);

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic gcEnable = 0, busFree = 0, isMaster = 0, slaveActive = 0;
  logic stateEnter = 0, stateIsIdle = 0, byteSent = 0;
  logic addrMatch = 0, genCallSeen = 0;
  logic irq, sclHold, busActive, cmdStart, cmdRepStart, cmdStop;
  logic cmdLocalStop, cmdRelease, ackValue, addrAccept;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  i2c_cmd_seq uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .gcEnable(gcEnable), .busFree(busFree),
    .isMaster(isMaster), .slaveActive(slaveActive), .stateEnter(stateEnter),
    .stateIsIdle(stateIsIdle), .byteSent(byteSent), .addrMatch(addrMatch),
    .genCallSeen(genCallSeen), .irq(irq), .sclHold(sclHold),
    .busActive(busActive), .cmdStart(cmdStart), .cmdRepStart(cmdRepStart),
    .cmdStop(cmdStop), .cmdLocalStop(cmdLocalStop), .cmdRelease(cmdRelease),
    .ackValue(ackValue), .addrAccept(addrAccept)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cmds();
    return {cmdStart, cmdRepStart, cmdStop, cmdLocalStop};
  endfunction

  // write at a negedge; returns at the next negedge with the write applied
  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // row: wr, data[7:0], enter, idle, expFlag, expIrq, expRel
  localparam logic [13:0] TBL [0:10] = '{
    {1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'hC8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'h48, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'hC0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset word", regRdData, 8'h00);
    chk("R2 reset irq/hold", {6'b0, irq, sclHold}, 8'h00);
    chk("R9 reset cmds", {4'b0, cmds()}, 8'h00);

    // table walk: flag, interrupt, release (R2 R10 R11 R3)
    for (int i = 0; i < 11; i++) begin
      regWrEn = TBL[i][13]; regWrData = TBL[i][12:5];
      stateEnter = TBL[i][4]; stateIsIdle = TBL[i][3];
      @(negedge clk);
      regWrEn = 1'b0; stateEnter = 1'b0; stateIsIdle = 1'b0;
      chk($sformatf("R10/R11 flag row %0d", i), {7'b0, regRdData[3]}, {7'b0, TBL[i][2]});
      chk($sformatf("R2 irq row %0d", i), {7'b0, irq}, {7'b0, TBL[i][1]});
      chk($sformatf("R10 sclHold row %0d", i), {7'b0, sclHold}, {7'b0, TBL[i][2]});
      chk($sformatf("R11 release row %0d", i), {7'b0, cmdRelease}, {7'b0, TBL[i][0]});
    end

    // R12 acknowledge level
    wr(8'h44);
    chk("R12 ack on", {7'b0, ackValue}, 8'h01);
    wr(8'h40);
    chk("R12 nack", {7'b0, ackValue}, 8'h00);

    // R3 address answering
    addrMatch = 1; #1;
    chk("R3 own address", {7'b0, addrAccept}, 8'h01);
    addrMatch = 0; genCallSeen = 1; #1;
    chk("R3 gc disabled", {7'b0, addrAccept}, 8'h00);
    gcEnable = 1; #1;
    chk("R3 gc enabled", {7'b0, addrAccept}, 8'h01);
    genCallSeen = 0; gcEnable = 0;
    wr(8'h00);
    addrMatch = 1; #1;
    chk("R3 off ignores address", {7'b0, addrAccept}, 8'h00);
    chk("R3 input gate off", {7'b0, busActive}, 8'h00);
    addrMatch = 0;
    wr(8'h20);
    busFree = 1; #1;
    chk("R3 no start when off", {4'b0, cmds()}, 8'h00);
    busFree = 0;
    @(negedge clk);
    wr(8'h40); // clears pending start bit? no: writing 0 keeps it
    chk("R7 start kept after 0 write", {7'b0, regRdData[5]}, 8'h01);

    // R4 start waits for free bus
    @(negedge clk);
    chk("R4 waits busy", {4'b0, cmds()}, 8'h00);
    busFree = 1; #1;
    chk("R4 start issued", {4'b0, cmds()}, 8'h08);
    @(negedge clk);
    chk("R4 start bit cleared", {7'b0, regRdData[5]}, 8'h00);
    chk("R4 single pulse", {4'b0, cmds()}, 8'h00);

    // R5 repeated start as master
    isMaster = 1; busFree = 0;
    wr(8'h60);
    chk("R5 no byte yet", {4'b0, cmds()}, 8'h00);
    byteSent = 1;
    @(negedge clk);
    byteSent = 0;
    chk("R5 repeated start", {4'b0, cmds()}, 8'h04);
    @(negedge clk);
    chk("R5 start bit cleared", {7'b0, regRdData[5]}, 8'h00);

    // R8 stop as master, then local stop as slave
    wr(8'h50);
    chk("R8 master stop", {4'b0, cmds()}, 8'h02);
    @(negedge clk);
    chk("R8 stop bit cleared", {7'b0, regRdData[4]}, 8'h00);
    isMaster = 0;
    wr(8'h50);
    chk("R8 local stop", {4'b0, cmds()}, 8'h01);
    @(negedge clk);
    chk("R8 local stop cleared", {7'b0, regRdData[4]}, 8'h00);

    // R6 start deferred during slave transfer
    slaveActive = 1; busFree = 1;
    wr(8'h60);
    chk("R6 wait slave", {4'b0, cmds()}, 8'h00);
    @(negedge clk);
    chk("R6 still waiting", {4'b0, cmds()}, 8'h00);
    slaveActive = 0; #1;
    chk("R6 start after slave", {4'b0, cmds()}, 8'h08);
    @(negedge clk);

    // R9 stop then start while master
    isMaster = 1; busFree = 0;
    byteSent = 1; @(negedge clk); byteSent = 0;
    wr(8'h70);
    chk("R9 stop first", {4'b0, cmds()}, 8'h02);
    @(negedge clk);
    chk("R9 no start while master", {4'b0, cmds()}, 8'h00);
    chk("R9 start still pending", {7'b0, regRdData[5]}, 8'h01);
    isMaster = 0;
    @(negedge clk);
    chk("R9 waits busy bus", {4'b0, cmds()}, 8'h00);
    busFree = 1; #1;
    chk("R9 start follows", {4'b0, cmds()}, 8'h08);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule